// File: doc/BRIEF.md
# Latency-Aware Register Ready Scoreboard

This block tracks when the pending result of each architectural register becomes usable by a later operation. It keeps one integer file and one floating-point file of 32 registers each. When an operation issues, its class and destination register are recorded, together with a down-counter loaded with the class's full result latency. The counter then decreases by one every cycle until it reaches zero.

A query names a source register, the file it belongs to, and the class of the consuming operation. The block raises a stall flag while that consumer cannot yet take the value. The consumer class matters because some producer and consumer pairs have forwarding paths that deliver the result early. In the most extreme case, a simple integer result reaches the data operand of a store in the same cycle it issues. The query is combinational on the stored state, so the flag answers for the current cycle. An issue takes effect at the next clock edge.

A consumer querying k cycles after its producer's issue edge (k = 0 is the cycle right after that edge) is ready once k reaches the effective latency of the pair.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset, no register stalls any consumer.
- R2: For a generic consumer (class code 11, used for addresses and all uses not listed below), the effective latency is: 1 for a load (code 12); 2 for an integer add or logical op (code 1); 2 for a shift or conditional move (code 2); 2 for a compare (code 3).
- R3: An add or logical result (code 1) has effective latency 1 for each of these consumer codes: branch (9), add/logical (1), shift (2), compare (3), 32-bit multiply (4) and 64-bit multiply (5).
- R4: A compare result (code 3) has effective latency 1 for a branch consumer (code 9) and 2 for an add/logical consumer (code 1). A shift result (code 2) has latency 2 for an add/logical consumer.
- R5: Results of add/logical (1), shift (2) and compare (3) have effective latency 0 for a store-data consumer (code 10). For an address consumer (code 11) they keep latency 2.
- R6: A 32-bit multiply (code 4) has latency 21, or 20 for store data (code 10). A 64-bit multiply (code 5) has latency 23, or 22 for store data.
- R7: A floating-point add/multiply/copy/select op (code 6) has latency 6. When the consumer is another code 6 op, its latency is 4.
- R8: A single-precision divide (code 7) has latency 34 and a double-precision divide (code 8) has latency 63.
- R9: Class code 0 (trap-like) has no effect when issued. As a consumer, class code 0 never stalls.
- R10: A new producer to a register replaces the pending class and counter, whether the new latency is longer or shorter.
- R11: Register 31 of each file is always ready, and issues that target it are ignored.
- R12: The two files are independent. The file flag (0 integer, 1 floating point) selects the file, so register n of one file does not affect register n of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An operation issues this cycle |
| iss_fp | input | 1 | Destination file of the issuing operation (1 = floating point) |
| iss_dst | input | 5 | Destination register of the issuing operation |
| iss_cls | input | 4 | Class code of the issuing operation |
| q_fp | input | 1 | File of the queried source register |
| q_src | input | 5 | Queried source register |
| q_cls | input | 4 | Class code of the consuming operation |
| q_stall | output | 1 | High while the consumer must wait for the queried register |

## Verification
Assertions check properties that hold on every cycle. Register 31 and class 0 queries never stall. A valid issue loads its latency into the named entry. Every other non-zero counter moves down by exactly one. The per-pair latencies (forwarding shortcuts, the store-data cases and the long divide times) can only be shown by the bench. Its scenarios issue a producer and then count the cycles until the stall flag drops for a chosen consumer. The bench also shows that an overwrite replaces the pending latency and that the two files are independent.

// File: rtl/lat_scoreboard.sv
module lat_scoreboard #(
  parameter int NREG = 32,
  parameter int CW = 6,
  parameter int KW = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             iss_fp,
  input  logic [IDX_W-1:0] iss_dst,
  input  logic [KW-1:0]    iss_cls,
  input  logic             q_fp,
  input  logic [IDX_W-1:0] q_src,
  input  logic [KW-1:0]    q_cls,
  output logic             q_stall
);
  localparam int NE = 2 * NREG;
  localparam int IW = IDX_W + 1;
  localparam logic [IDX_W-1:0] ZREG = IDX_W'(NREG - 1);

  localparam logic [KW-1:0] C_NONE  = KW'(0);
  localparam logic [KW-1:0] C_ALU   = KW'(1);
  localparam logic [KW-1:0] C_SHF   = KW'(2);
  localparam logic [KW-1:0] C_CMP   = KW'(3);
  localparam logic [KW-1:0] C_MULW  = KW'(4);
  localparam logic [KW-1:0] C_MULD  = KW'(5);
  localparam logic [KW-1:0] C_FOP   = KW'(6);
  localparam logic [KW-1:0] C_DIVS  = KW'(7);
  localparam logic [KW-1:0] C_DIVD  = KW'(8);
  localparam logic [KW-1:0] C_BR    = KW'(9);
  localparam logic [KW-1:0] C_STD   = KW'(10);
  localparam logic [KW-1:0] C_LD    = KW'(12);

  function automatic logic [CW-1:0] full_lat(input logic [KW-1:0] c);
    case (c)
      C_LD:          full_lat = CW'(1);
      C_ALU, C_SHF,
      C_CMP:         full_lat = CW'(2);
      C_MULW:        full_lat = CW'(21);
      C_MULD:        full_lat = CW'(23);
      C_FOP:         full_lat = CW'(6);
      C_DIVS:        full_lat = CW'(34);
      C_DIVD:        full_lat = CW'(63);
      default:       full_lat = '0;
    endcase
  endfunction

  // cycles saved by forwarding for a producer/consumer pair
  function automatic logic [CW-1:0] saved(input logic [KW-1:0] p, input logic [KW-1:0] c);
    saved = '0;
    case (p)
      C_ALU: begin
        if (c == C_STD) saved = CW'(2);
        else if (c == C_BR || c == C_ALU || c == C_SHF || c == C_CMP ||
                 c == C_MULW || c == C_MULD) saved = CW'(1);
      end
      C_SHF:  if (c == C_STD) saved = CW'(2);
      C_CMP: begin
        if (c == C_STD) saved = CW'(2);
        else if (c == C_BR) saved = CW'(1);
      end
      C_MULW, C_MULD: if (c == C_STD) saved = CW'(1);
      C_FOP:  if (c == C_FOP) saved = CW'(2);
      default: saved = '0;
    endcase
  endfunction

  logic [CW-1:0] cnt [NE];
  logic [KW-1:0] pcl [NE];

  wire [IW-1:0] wr_idx = {iss_fp, iss_dst};
  wire [IW-1:0] rd_idx = {q_fp, q_src};
  wire [CW-1:0] wr_lat = full_lat(iss_cls);
  wire          wr_en  = iss_valid && (wr_lat != '0) && (iss_dst != ZREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        cnt[i] <= '0;
        pcl[i] <= C_NONE;
      end
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (wr_en && wr_idx == IW'(i)) begin
          cnt[i] <= wr_lat;
          pcl[i] <= iss_cls;
        end else if (cnt[i] != '0) begin
          cnt[i] <= cnt[i] - CW'(1);
        end
      end
    end
  end

  assign q_stall = (q_src != ZREG) && (q_cls != C_NONE) &&
                   (cnt[rd_idx] > saved(pcl[rd_idx], q_cls));

  AST_R31_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_src == ZREG) |-> !q_stall); // R11
  AST_TRAP_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cls == C_NONE) |-> !q_stall); // R9
  AST_ISSUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt[$past(wr_idx)] == $past(wr_lat))); // R10

  for (genvar g = 0; g < NE; g++) begin : g_chk
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] != '0 && !(wr_en && wr_idx == IW'(g))) |=>
      (cnt[g] == $past(cnt[g]) - CW'(1))); // R2
  end
endmodule

// File: tb/lat_scoreboard_tb.sv
module lat_scoreboard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_fp = 1'b0, q_fp = 1'b0;
  logic [4:0] iss_dst = '0, q_src = '0;
  logic [3:0] iss_cls = '0, q_cls = '0;
  logic q_stall;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lat_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fp(iss_fp),
    .iss_dst(iss_dst), .iss_cls(iss_cls), .q_fp(q_fp), .q_src(q_src),
    .q_cls(q_cls), .q_stall(q_stall));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_issue(input bit fp, input int dst, input int cls);
    @(negedge clk);
    iss_valid = 1'b1; iss_fp = fp; iss_dst = 5'(dst); iss_cls = 4'(cls);
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic measure(input bit fp, input int src, input int cls, output int k);
    q_fp = fp; q_src = 5'(src); q_cls = 4'(cls);
    #1;
    k = 0;
    while (q_stall && k < 80) begin
      @(posedge clk); #1;
      k++;
    end
  endtask

  task automatic pair(input bit fp, input int dst, input int pc, input int cc,
                      input int exp, input string tag);
    int k;
    do_issue(fp, dst, pc);
    measure(fp, dst, cc, k);
    check(k == exp, tag, k, exp);
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        q_fp = f[0]; q_src = 5'(r); q_cls = 4'd11; #1;
        if (q_stall) bad++;
      end
    check(bad == 0, "R1 reset ready", bad, 0);
  endtask

  task automatic t_defaults;
    pair(0, 1, 12, 11, 1, "R2 load");
    pair(0, 2, 1, 11, 2, "R2 alu");
    pair(0, 3, 2, 11, 2, "R2 shift");
    pair(0, 4, 3, 11, 2, "R2 cmp");
  endtask

  task automatic t_alu_fwd;
    pair(0, 5, 1, 9, 1, "R3 alu->br");
    pair(0, 5, 1, 1, 1, "R3 alu->alu");
    pair(0, 6, 1, 2, 1, "R3 alu->shift");
    pair(0, 6, 1, 3, 1, "R3 alu->cmp");
    pair(0, 7, 1, 4, 1, "R3 alu->mul32");
    pair(0, 7, 1, 5, 1, "R3 alu->mul64");
  endtask

  task automatic t_cmp;
    pair(0, 8, 3, 9, 1, "R4 cmp->br");
    pair(0, 8, 3, 1, 2, "R4 cmp->alu");
    pair(0, 9, 2, 1, 2, "R4 shift->alu");
  endtask

  task automatic t_store;
    pair(0, 10, 1, 10, 0, "R5 alu->stdata");
    pair(0, 10, 2, 10, 0, "R5 shift->stdata");
    pair(0, 11, 3, 10, 0, "R5 cmp->stdata");
    pair(0, 11, 1, 11, 2, "R5 alu->addr");
  endtask

  task automatic t_mul;
    pair(0, 12, 4, 1, 21, "R6 mul32");
    pair(0, 12, 4, 10, 20, "R6 mul32->stdata");
    pair(0, 13, 5, 11, 23, "R6 mul64");
    pair(0, 13, 5, 10, 22, "R6 mul64->stdata");
  endtask

  task automatic t_fp;
    pair(1, 2, 6, 11, 6, "R7 fop");
    pair(1, 2, 6, 6, 4, "R7 fop->fop");
    pair(1, 3, 6, 10, 6, "R7 fop->stdata");
  endtask

  task automatic t_div;
    pair(1, 4, 7, 11, 34, "R8 div single");
    pair(1, 5, 8, 11, 63, "R8 div double");
  endtask

  task automatic t_trap;
    int k;
    do_issue(0, 14, 5);
    do_issue(0, 14, 0);
    measure(0, 14, 11, k);
    check(k == 22, "R9 trap issue ignored", k, 22);
    do_issue(0, 15, 5);
    q_fp = 0; q_src = 5'd15; q_cls = 4'd0; #1;
    check(q_stall == 1'b0, "R9 trap consumer", q_stall, 0);
  endtask

  task automatic t_overwrite;
    int k;
    do_issue(0, 16, 5);
    do_issue(0, 16, 1);
    measure(0, 16, 11, k);
    check(k == 2, "R10 shorter overwrite", k, 2);
    do_issue(0, 17, 1);
    do_issue(0, 17, 4);
    measure(0, 17, 11, k);
    check(k == 21, "R10 longer overwrite", k, 21);
  endtask

  task automatic t_r31;
    int k;
    do_issue(0, 31, 5);
    measure(0, 31, 11, k);
    check(k == 0, "R11 int r31", k, 0);
    do_issue(1, 31, 8);
    measure(1, 31, 6, k);
    check(k == 0, "R11 fp r31", k, 0);
  endtask

  task automatic t_files;
    int k;
    do_issue(0, 20, 5);
    measure(1, 20, 6, k);
    check(k == 0, "R12 fp untouched", k, 0);
    measure(0, 20, 11, k);
    check(k == 23, "R12 int pending", k, 23);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_defaults;
    t_alu_fwd;
    t_cmp;
    t_store;
    t_mul;
    t_fp;
    t_div;
    t_trap;
    t_overwrite;
    t_r31;
    t_files;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule